// File: doc/BRIEF.md
# Partial-Store Edge Mask Generator

This block turns the first and last byte addresses of a memory span into a lane enable mask for a partial store. Memory is seen as 8-byte blocks, and each block is split into lanes of 8, 16 or 32 bits. For the first block of a span, the mask enables the lanes from the start address to the end of that block. When the span starts and ends in the same block, the mask keeps only the lanes between the two addresses. The caller can choose the lane numbering order within a block: big-endian (lane 0 in the most significant mask bit) or little-endian (lane 0 in the least significant mask bit).

On request the block also returns condition flags from subtracting the end address from the start address. The flags come in two sets: one for the full 64-bit values and one for their low 32 bits. A 32-bit addressing mode restricts the block comparison to the low 32 address bits. A request is a one-cycle strobe. The result is registered and appears in the following cycle. All results hold until the next request.

Top module: `edge_mask_gen`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) clears `edgeMask`, `flagsWide`, `flagsNarrow`, `respValid` and `flagsValid` to zero.
- R2: `respValid` is high in exactly the cycle after a cycle with `reqValid` high. Between requests, `edgeMask` and the flag outputs keep their values.
- R3: When `elemSize` is 0 (8-bit lanes) and `littleEnd` is 0, let n = `startAddr[2:0]` and m = `endAddr[2:0]`. The left mask is 0xFF >> n and the right mask is (0xFF << (7-m)) & 0xFF.
- R4: When `elemSize` is 0 and `littleEnd` is 1, the left mask is (0xFF << n) & 0xFF and the right mask is 0xFF >> (7-m).
- R5: When `elemSize` is 1 (16-bit lanes), the lane index comes from address bits [2:1]. The 4-bit masks are: big-endian left 0xF,0x7,0x3,0x1 and right 0x8,0xC,0xE,0xF; little-endian left 0xF,0xE,0xC,0x8 and right 0x1,0x3,0x7,0xF (listed for index 0..3).
- R6: When `elemSize` is 2 (32-bit lanes), the lane index is address bit 2. The 2-bit masks are: big-endian left 3,1 and right 2,3; little-endian left 3,2 and right 1,3.
- R7: If `startAddr[63:3]` equals `endAddr[63:3]`, `edgeMask` is left AND right. Otherwise `edgeMask` is the left mask alone.
- R8: When `addr32` is 1, only bits [31:3] of the two addresses take part in the same-block comparison.
- R9: Masks for 16-bit and 32-bit lanes are zero-extended into the 8-bit `edgeMask`. `elemSize` value 3 behaves as 0.
- R10: When `setFlags` is 1, `flagsWide` holds the flags of `startAddr - endAddr` over 64 bits, always on the untruncated addresses. `flagsNarrow` holds the same flags over bits [31:0]. Bit 3 is negative, bit 2 is zero, bit 1 is signed overflow and bit 0 is carry (borrow, set when start < end unsigned). `flagsValid` then reads 1.
- R11: When `setFlags` is 0, a request clears `flagsWide` and `flagsNarrow` to zero and `flagsValid` reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| reqValid | input | 1 | One-cycle request strobe |
| startAddr | input | 64 | Start byte address of the span |
| endAddr | input | 64 | End byte address of the span |
| elemSize | input | 2 | Lane size: 0 = 8-bit, 1 = 16-bit, 2 = 32-bit, 3 = 8-bit |
| littleEnd | input | 1 | 1 selects little-endian lane order |
| setFlags | input | 1 | 1 requests subtraction flags |
| addr32 | input | 1 | 1 limits block comparison to low 32 bits |
| respValid | output | 1 | Result strobe, one cycle after the request |
| edgeMask | output | 8 | Lane enable mask, zero-extended |
| flagsValid | output | 1 | Flag outputs hold flags of the last request |
| flagsWide | output | 4 | N,Z,V,C of the 64-bit subtraction |
| flagsNarrow | output | 4 | N,Z,V,C of the 32-bit subtraction |

## Verification
Each result is registered, so a wrong lane index, lane order or size selection appears on `edgeMask` in the cycle after the request. It shows up as a missing or extra lane, or as a nonzero upper nibble for wide lanes. A broken same-block comparison only shows when one address pair crosses a block boundary and another pair does not. For that reason the directed cases include pairs that differ only in the top address bit, pairs that differ only in bits above 31, and adjacent blocks. Errors in the flags show up as an inconsistent N/Z/V/C pattern in the same cycle, or as flags left standing after a request that has flag setting disabled.

// File: rtl/edge_mask_pkg.sv
package edge_mask_pkg;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_RSVD = 2'd3
  } elemSize_e;

  typedef struct packed {
    logic load;
    logic loadFlags;
    logic clearFlags;
  } ctrlStrobe_t;

  typedef struct packed {
    logic neg;
    logic zero;
    logic ovf;
    logic carry;
  } flags_t;

endpackage

// File: rtl/edge_lane_mask.sv
module edge_lane_mask #(
  parameter int LANES  = 8,
  parameter int MASK_W = 8,
  localparam int IDX_W = (LANES > 1) ? $clog2(LANES) : 1
) (
  input  logic [IDX_W-1:0]  startIdx,
  input  logic [IDX_W-1:0]  endIdx,
  input  logic              littleEnd,
  output logic [MASK_W-1:0] leftMask,
  output logic [MASK_W-1:0] rightMask
);

  localparam logic [LANES-1:0] FULL = {LANES{1'b1}};
  localparam logic [IDX_W-1:0] TOP_IDX = IDX_W'(LANES - 1);

  logic [IDX_W-1:0] endRev;
  logic [LANES-1:0] leftNarrow;
  logic [LANES-1:0] rightNarrow;

  always_comb begin
    endRev = TOP_IDX - endIdx;
    if (littleEnd) begin
      leftNarrow  = FULL << startIdx;
      rightNarrow = FULL >> endRev;
    end else begin
      leftNarrow  = FULL >> startIdx;
      rightNarrow = FULL << endRev;
    end
    leftMask  = MASK_W'(leftNarrow);
    rightMask = MASK_W'(rightNarrow);
  end

endmodule

// File: rtl/edge_sub_flags.sv
module edge_sub_flags
  import edge_mask_pkg::*;
#(
  parameter int W = 64
) (
  input  logic [W-1:0] minuend,
  input  logic [W-1:0] subtrahend,
  output flags_t       flags
);

  logic [W:0] diff;

  always_comb begin
    diff        = {1'b0, minuend} - {1'b0, subtrahend};
    flags.carry = diff[W];
    flags.neg   = diff[W-1];
    flags.zero  = (diff[W-1:0] == '0);
    flags.ovf   = (minuend[W-1] ^ subtrahend[W-1]) & (diff[W-1] ^ minuend[W-1]);
  end

endmodule

// File: rtl/edge_mask_ctrl.sv
module edge_mask_ctrl
  import edge_mask_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        reqValid,
  input  logic        setFlags,
  output ctrlStrobe_t strobe,
  output logic        respValid,
  output logic        flagsValid
);

  always_comb begin
    strobe.load       = reqValid;
    strobe.loadFlags  = reqValid & setFlags;
    strobe.clearFlags = reqValid & ~setFlags;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      respValid  <= 1'b0;
      flagsValid <= 1'b0;
    end else begin
      respValid <= reqValid;
      if (reqValid) flagsValid <= setFlags;
    end
  end

  a_r2_resp_follows_req: assert property (@(posedge clk) disable iff (rst)
    reqValid |=> respValid);

  a_r2_no_resp_without_req: assert property (@(posedge clk) disable iff (rst)
    !reqValid |=> !respValid);

  a_r11_flags_valid_drops: assert property (@(posedge clk) disable iff (rst)
    (reqValid && !setFlags) |=> !flagsValid);

endmodule

// File: rtl/edge_mask_datapath.sv
module edge_mask_datapath
  import edge_mask_pkg::*;
#(
  parameter int ADDR_W      = 64,
  parameter int NARROW_W    = 32,
  parameter int BLOCK_BYTES = 8,
  localparam int MASK_W     = BLOCK_BYTES
) (
  input  logic              clk,
  input  logic              rst,
  input  ctrlStrobe_t       strobe,
  input  logic [ADDR_W-1:0] startAddr,
  input  logic [ADDR_W-1:0] endAddr,
  input  logic [1:0]        elemSize,
  input  logic              littleEnd,
  input  logic              addr32,
  output logic [MASK_W-1:0] edgeMask,
  output flags_t            flagsWide,
  output flags_t            flagsNarrow
);

  localparam int BLK_LSB   = $clog2(BLOCK_BYTES);
  localparam int NUM_SIZES = BLK_LSB;

  logic [MASK_W-1:0] leftSet  [NUM_SIZES];
  logic [MASK_W-1:0] rightSet [NUM_SIZES];

  for (genvar g = 0; g < NUM_SIZES; g++) begin : g_size
    edge_lane_mask #(
      .LANES (BLOCK_BYTES >> g),
      .MASK_W(MASK_W)
    ) u_lane (
      .startIdx (startAddr[BLK_LSB-1:g]),
      .endIdx   (endAddr[BLK_LSB-1:g]),
      .littleEnd(littleEnd),
      .leftMask (leftSet[g]),
      .rightMask(rightSet[g])
    );
  end

  elemSize_e         sizeSel;
  logic [ADDR_W-1:0] effStart;
  logic [ADDR_W-1:0] effEnd;
  logic              sameBlock;
  logic [MASK_W-1:0] pickLeft;
  logic [MASK_W-1:0] pickRight;
  logic [MASK_W-1:0] nextMask;

  always_comb begin
    sizeSel = elemSize_e'(elemSize);
    if (sizeSel == SZ_RSVD) sizeSel = SZ_BYTE;
    pickLeft  = leftSet[sizeSel];
    pickRight = rightSet[sizeSel];
    effStart  = addr32 ? ADDR_W'(startAddr[NARROW_W-1:0]) : startAddr;
    effEnd    = addr32 ? ADDR_W'(endAddr[NARROW_W-1:0])   : endAddr;
    sameBlock = (effStart[ADDR_W-1:BLK_LSB] == effEnd[ADDR_W-1:BLK_LSB]);
    nextMask  = sameBlock ? (pickLeft & pickRight) : pickLeft;
  end

  flags_t wideNext;
  flags_t narrowNext;

  edge_sub_flags #(.W(ADDR_W)) u_flags_wide (
    .minuend   (startAddr),
    .subtrahend(endAddr),
    .flags     (wideNext)
  );

  edge_sub_flags #(.W(NARROW_W)) u_flags_narrow (
    .minuend   (startAddr[NARROW_W-1:0]),
    .subtrahend(endAddr[NARROW_W-1:0]),
    .flags     (narrowNext)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      edgeMask    <= '0;
      flagsWide   <= '0;
      flagsNarrow <= '0;
    end else begin
      if (strobe.load) edgeMask <= nextMask;
      if (strobe.loadFlags) begin
        flagsWide   <= wideNext;
        flagsNarrow <= narrowNext;
      end else if (strobe.clearFlags) begin
        flagsWide   <= '0;
        flagsNarrow <= '0;
      end
    end
  end

  a_r2_mask_holds: assert property (@(posedge clk) disable iff (rst)
    !strobe.load |=> $stable(edgeMask));

  a_r9_half_zero_ext: assert property (@(posedge clk) disable iff (rst)
    (strobe.load && elemSize == SZ_HALF) |=> (edgeMask[MASK_W-1:MASK_W/2] == '0));

  a_r10_zero_implies_quiet: assert property (@(posedge clk) disable iff (rst)
    flagsWide.zero |-> (!flagsWide.neg && !flagsWide.ovf && !flagsWide.carry));

  a_r10_wide_zero_narrow_zero: assert property (@(posedge clk) disable iff (rst)
    flagsWide.zero |-> flagsNarrow.zero);

  a_r11_flags_cleared: assert property (@(posedge clk) disable iff (rst)
    strobe.clearFlags |=> (flagsWide == '0 && flagsNarrow == '0));

endmodule

// File: rtl/edge_mask_gen.sv
module edge_mask_gen
  import edge_mask_pkg::*;
#(
  parameter int ADDR_W      = 64,
  parameter int NARROW_W    = 32,
  parameter int BLOCK_BYTES = 8
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   reqValid,
  input  logic [ADDR_W-1:0]      startAddr,
  input  logic [ADDR_W-1:0]      endAddr,
  input  logic [1:0]             elemSize,
  input  logic                   littleEnd,
  input  logic                   setFlags,
  input  logic                   addr32,
  output logic                   respValid,
  output logic [BLOCK_BYTES-1:0] edgeMask,
  output logic                   flagsValid,
  output logic [3:0]             flagsWide,
  output logic [3:0]             flagsNarrow
);

  ctrlStrobe_t strobe;
  flags_t      wideReg;
  flags_t      narrowReg;

  edge_mask_ctrl u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .reqValid  (reqValid),
    .setFlags  (setFlags),
    .strobe    (strobe),
    .respValid (respValid),
    .flagsValid(flagsValid)
  );

  edge_mask_datapath #(
    .ADDR_W     (ADDR_W),
    .NARROW_W   (NARROW_W),
    .BLOCK_BYTES(BLOCK_BYTES)
  ) u_dp (
    .clk        (clk),
    .rst        (rst),
    .strobe     (strobe),
    .startAddr  (startAddr),
    .endAddr    (endAddr),
    .elemSize   (elemSize),
    .littleEnd  (littleEnd),
    .addr32     (addr32),
    .edgeMask   (edgeMask),
    .flagsWide  (wideReg),
    .flagsNarrow(narrowReg)
  );

  assign flagsWide   = wideReg;
  assign flagsNarrow = narrowReg;

endmodule

// File: tb/edge_mask_gen_tb.sv
`timescale 1ns/1ps
module edge_mask_gen_tb;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reqValid = 1'b0;
  logic [63:0] startAddr = '0;
  logic [63:0] endAddr = '0;
  logic [1:0]  elemSize = '0;
  logic        littleEnd = 1'b0;
  logic        setFlags = 1'b0;
  logic        addr32 = 1'b0;
  logic        respValid;
  logic [7:0]  edgeMask;
  logic        flagsValid;
  logic [3:0]  flagsWide;
  logic [3:0]  flagsNarrow;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  edge_mask_gen u_dut (
    .clk(clk), .rst(rst), .reqValid(reqValid), .startAddr(startAddr),
    .endAddr(endAddr), .elemSize(elemSize), .littleEnd(littleEnd),
    .setFlags(setFlags), .addr32(addr32), .respValid(respValid),
    .edgeMask(edgeMask), .flagsValid(flagsValid), .flagsWide(flagsWide),
    .flagsNarrow(flagsNarrow)
  );

  function automatic logic [7:0] expMask(input logic [1:0] sz, input logic le,
                                         input logic a32, input logic [63:0] s,
                                         input logic [63:0] e);
    int ls;
    int lanes;
    int n;
    int m;
    logic [7:0] l;
    logic [7:0] r;
    logic same;
    ls = (sz == 2'd3) ? 0 : int'(sz);
    lanes = 8 >> ls;
    n = int'(s[2:0]) >> ls;
    m = int'(e[2:0]) >> ls;
    l = '0;
    r = '0;
    for (int i = 0; i < lanes; i++) begin
      int pos;
      pos = le ? i : (lanes - 1 - i);
      if (i >= n) l[pos] = 1'b1;
      if (i <= m) r[pos] = 1'b1;
    end
    same = a32 ? (s[31:3] == e[31:3]) : (s[63:3] == e[63:3]);
    return same ? (l & r) : l;
  endfunction

  function automatic logic [3:0] expFlags64(input logic [63:0] a, input logic [63:0] b);
    logic [63:0] d;
    logic nf;
    d = a - b;
    nf = d[63];
    return {nf, d == 64'd0, ($signed(a) < $signed(b)) != nf, a < b};
  endfunction

  function automatic logic [3:0] expFlags32(input logic [31:0] a, input logic [31:0] b);
    logic [31:0] d;
    logic nf;
    d = a - b;
    nf = d[31];
    return {nf, d == 32'd0, ($signed(a) < $signed(b)) != nf, a < b};
  endfunction

  task automatic check(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic issue(input logic [1:0] sz, input logic le, input logic sf,
                       input logic a32, input logic [63:0] s, input logic [63:0] e);
    @(negedge clk);
    reqValid = 1'b1; elemSize = sz; littleEnd = le; setFlags = sf;
    addr32 = a32; startAddr = s; endAddr = e;
    @(negedge clk);
    reqValid = 1'b0;
  endtask

  task automatic runCase(input string req, input logic [1:0] sz, input logic le,
                         input logic sf, input logic a32, input logic [63:0] s,
                         input logic [63:0] e);
    issue(sz, le, sf, a32, s, e);
    check("R2", "respValid", 64'(respValid), 64'd1);
    check(req, "edgeMask", 64'(edgeMask), 64'(expMask(sz, le, a32, s, e)));
    if (sf) begin
      check("R10", "flagsWide", 64'(flagsWide), 64'(expFlags64(s, e)));
      check("R10", "flagsNarrow", 64'(flagsNarrow), 64'(expFlags32(s[31:0], e[31:0])));
      check("R10", "flagsValid", 64'(flagsValid), 64'd1);
    end
  endtask

  task automatic t_reset;
    check("R1", "edgeMask", 64'(edgeMask), 64'd0);
    check("R1", "flagsWide", 64'(flagsWide), 64'd0);
    check("R1", "flagsNarrow", 64'(flagsNarrow), 64'd0);
    check("R1", "respValid", 64'(respValid), 64'd0);
    check("R1", "flagsValid", 64'(flagsValid), 64'd0);
  endtask

  task automatic t_byte_be;
    for (int n = 0; n < 8; n++) begin
      runCase("R3", 2'd0, 1'b0, 1'b0, 1'b0, 64'h1000 + 64'(n), 64'h2000 + 64'(7 - n));
      runCase("R3", 2'd0, 1'b0, 1'b0, 1'b0, 64'h1000 + 64'(n), 64'h1000 + 64'(7 - n));
    end
    runCase("R3", 2'd0, 1'b0, 1'b0, 1'b0, 64'h1005, 64'h1002);
  endtask

  task automatic t_byte_le;
    for (int n = 0; n < 8; n++) begin
      runCase("R4", 2'd0, 1'b1, 1'b0, 1'b0, 64'h40 + 64'(n), 64'h80);
      runCase("R4", 2'd0, 1'b1, 1'b0, 1'b0, 64'h40 + 64'(n), 64'h47);
      runCase("R4", 2'd0, 1'b1, 1'b0, 1'b0, 64'h40, 64'h40 + 64'(n));
    end
  endtask

  task automatic t_half;
    for (int n = 0; n < 8; n++) begin
      runCase("R5", 2'd1, 1'b0, 1'b0, 1'b0, 64'h200 + 64'(n), 64'h300 + 64'(n));
      runCase("R5", 2'd1, 1'b1, 1'b0, 1'b0, 64'h200 + 64'(n), 64'h300 + 64'(n));
      runCase("R5", 2'd1, 1'b0, 1'b0, 1'b0, 64'h200, 64'h200 + 64'(n));
      runCase("R5", 2'd1, 1'b1, 1'b0, 1'b0, 64'h200, 64'h200 + 64'(n));
    end
  endtask

  task automatic t_word;
    for (int n = 0; n < 8; n++) begin
      runCase("R6", 2'd2, 1'b0, 1'b0, 1'b0, 64'h808 + 64'(n), 64'h900);
      runCase("R6", 2'd2, 1'b1, 1'b0, 1'b0, 64'h808 + 64'(n), 64'h900);
      runCase("R6", 2'd2, 1'b0, 1'b0, 1'b0, 64'h808, 64'h808 + 64'(n));
      runCase("R6", 2'd2, 1'b1, 1'b0, 1'b0, 64'h808, 64'h808 + 64'(n));
    end
  endtask

  task automatic t_block;
    runCase("R7", 2'd0, 1'b0, 1'b0, 1'b0, 64'h0000_0000_0000_1003, 64'h8000_0000_0000_1005);
    runCase("R7", 2'd0, 1'b0, 1'b0, 1'b0, 64'h1007, 64'h1008);
    runCase("R7", 2'd0, 1'b0, 1'b0, 1'b0, 64'h1003, 64'h1006);
    runCase("R7", 2'd1, 1'b1, 1'b0, 1'b0, 64'h1002, 64'h0FFE);
  endtask

  task automatic t_addr32;
    runCase("R8", 2'd0, 1'b0, 1'b0, 1'b1, 64'hABCD_0000_0000_1002, 64'h1234_0000_0000_1005);
    runCase("R8", 2'd0, 1'b0, 1'b0, 1'b0, 64'hABCD_0000_0000_1002, 64'h1234_0000_0000_1005);
    runCase("R8", 2'd0, 1'b1, 1'b0, 1'b1, 64'h0000_0001_0000_1002, 64'h0000_0001_0000_2005);
  endtask

  task automatic t_size_ext;
    runCase("R9", 2'd3, 1'b0, 1'b0, 1'b0, 64'h3003, 64'h3006);
    runCase("R9", 2'd3, 1'b1, 1'b0, 1'b0, 64'h3001, 64'h4000);
    runCase("R9", 2'd1, 1'b0, 1'b0, 1'b0, 64'h3000, 64'h4000);
    runCase("R9", 2'd2, 1'b1, 1'b0, 1'b0, 64'h3000, 64'h4000);
  endtask

  task automatic t_flags;
    runCase("R10", 2'd0, 1'b0, 1'b1, 1'b0, 64'h1000, 64'h1000);
    runCase("R10", 2'd0, 1'b0, 1'b1, 1'b0, 64'h1000, 64'h2000);
    runCase("R10", 2'd0, 1'b0, 1'b1, 1'b0, 64'h7FFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF);
    runCase("R10", 2'd0, 1'b0, 1'b1, 1'b0, 64'h8000_0000_0000_0000, 64'h1);
    runCase("R10", 2'd0, 1'b0, 1'b1, 1'b1, 64'h0000_0005_8000_0000, 64'h0000_0001_0000_0001);
    runCase("R10", 2'd0, 1'b0, 1'b1, 1'b1, 64'h0000_0002_0000_0010, 64'h0000_0001_0000_0010);
  endtask

  task automatic t_noflags;
    runCase("R11", 2'd0, 1'b0, 1'b1, 1'b0, 64'h10, 64'h30);
    runCase("R11", 2'd0, 1'b0, 1'b0, 1'b0, 64'h10, 64'h30);
    check("R11", "flagsWide", 64'(flagsWide), 64'd0);
    check("R11", "flagsNarrow", 64'(flagsNarrow), 64'd0);
    check("R11", "flagsValid", 64'(flagsValid), 64'd0);
  endtask

  task automatic t_hold;
    logic [7:0] keptMask;
    logic [3:0] keptFlags;
    runCase("R2", 2'd0, 1'b0, 1'b1, 1'b0, 64'h1002, 64'h1003);
    keptMask = edgeMask;
    keptFlags = flagsWide;
    @(negedge clk);
    startAddr = 64'h5000; endAddr = 64'h5007; setFlags = 1'b0; elemSize = 2'd1;
    repeat (3) @(negedge clk);
    check("R2", "respValid idle", 64'(respValid), 64'd0);
    check("R2", "edgeMask held", 64'(edgeMask), 64'(keptMask));
    check("R2", "flagsWide held", 64'(flagsWide), 64'(keptFlags));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_byte_be();
    t_byte_le();
    t_half();
    t_word();
    t_block();
    t_addr32();
    t_size_ext();
    t_flags();
    t_noflags();
    t_hold();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule